// File: doc/BRIEF.md
# Dual-Rail Early-Resolving Logic Cell

This cell computes a two-input AND or OR function on four-phase dual-rail operands. Each operand and the result travel as a pair of rails, one for true and one for false. Both rails low is the spacer (NULL). Exactly one rail high is a valid logic value. Static parameters pick the gate type, an inversion on each input and an inversion on the result. An inversion costs no gates: it only swaps the two rails of that signal.

A mode parameter selects how the cell decides. In early mode the result resolves as soon as the inputs present are enough to fix it. For OR that means one valid 1; for AND it means one valid 0. In completion mode the cell acts as a C-element gate. It leaves NULL only after both operands are valid, and it returns to NULL only after both are NULL. Between those two events it holds its value. That state is kept in a clocked set/reset register, and the result rails are registered in both modes. A valid flag and an input-fault flag go with the result.

Top module: `eo_gate`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge.
- R2: Rails are read as {true,false}: 00 is NULL, 01 is logic 0, 10 is logic 1, 11 is illegal. When both inputs are NULL at an edge, the result is NULL after that edge. With legal inputs the result never has both rails high.
- R3: Early mode, OR: if either effective input is a valid 1, the result is 1 after the next edge, even while the other input is NULL.
- R4: Early mode, OR: the result is 0 only when both effective inputs are valid 0. One valid 0 with the other input NULL gives NULL.
- R5: Early mode, AND: either effective input at valid 0 gives result 0 at once. The result is 1 only when both are valid 1. All other cases give NULL.
- R6: `INV_A`, `INV_B` and `INV_Y` invert their signal by swapping its true and false rails.
- R7: Completion mode: the result stays NULL while exactly one input is valid, and it takes the gate value once both are valid.
- R8: Completion mode: once valid, the result holds its value while only one input has returned to NULL. It becomes NULL only when both inputs are NULL.
- R9: `y_valid` equals the OR of `y_t` and `y_f`.
- R10: `in_fault` is 1 one edge after either input has both rails high, and 0 otherwise.
- R11: Every output changes only at a clock edge. It reflects the inputs sampled at that edge, so inputs that are valid at an edge yield a valid result after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_t | input | 1 | Operand A true rail |
| a_f | input | 1 | Operand A false rail |
| b_t | input | 1 | Operand B true rail |
| b_f | input | 1 | Operand B false rail |
| y_t | output | 1 | Result true rail |
| y_f | output | 1 | Result false rail |
| y_valid | output | 1 | Result carries a valid value |
| in_fault | output | 1 | An operand had both rails high at the previous edge |

## Verification
The hardest state to reach is completion mode holding a value while one operand has already returned to NULL. A plain sweep from NULL never passes through it. The bench therefore walks the operands through a full four-phase sequence: one valid, both valid, one withdrawn, both withdrawn. It checks the result at each step against a model that carries the held value forward. Five parameter sets are driven with the same stimulus, covering OR, AND, rail swaps and both modes. Every one of the nine operand combinations is swept on all of them.

// File: rtl/eo_pkg.sv
package eo_pkg;
  typedef struct packed {
    logic t;
    logic f;
  } rail_t;

  typedef enum logic {
    EO_EARLY = 1'b0,
    EO_DIMS  = 1'b1
  } mode_e;
endpackage

// File: rtl/eo_rail_swap.sv
module eo_rail_swap #(
  parameter bit SWAP = 1'b0
) (
  input  eo_pkg::rail_t din,
  output eo_pkg::rail_t dout
);
  generate
    if (SWAP) begin : g_swap
      assign dout.t = din.f;
      assign dout.f = din.t;
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/eo_resolve.sv
module eo_resolve #(
  parameter bit IS_OR = 1'b1
) (
  input  eo_pkg::rail_t a,
  input  eo_pkg::rail_t b,
  output eo_pkg::rail_t y,
  output logic          all_valid,
  output logic          all_null,
  output logic          bad
);
  logic a_ok, b_ok;

  assign a_ok      = a.t | a.f;
  assign b_ok      = b.t | b.f;
  assign all_valid = a_ok & b_ok;
  assign all_null  = ~a_ok & ~b_ok;
  assign bad       = (a.t & a.f) | (b.t & b.f);

  generate
    if (IS_OR) begin : g_or
      // a single 1 settles the result; 0 needs both operands
      assign y.t = a.t | b.t;
      assign y.f = a.f & b.f;
    end else begin : g_and
      // a single 0 settles the result; 1 needs both operands
      assign y.t = a.t & b.t;
      assign y.f = a.f | b.f;
    end
  endgenerate
endmodule

// File: rtl/eo_hold.sv
module eo_hold #(
  parameter eo_pkg::mode_e MODE = eo_pkg::EO_EARLY
) (
  input  logic          clk,
  input  logic          rst,
  input  eo_pkg::rail_t d,
  input  logic          all_valid,
  input  logic          all_null,
  input  logic          bad,
  output eo_pkg::rail_t q,
  output logic          q_valid,
  output logic          fault
);
  always_ff @(posedge clk) begin
    if (rst) fault <= 1'b0;
    else     fault <= bad;
  end

  generate
    if (MODE == eo_pkg::EO_DIMS) begin : g_dims
      // set/reset state of a completion gate
      always_ff @(posedge clk) begin
        if (rst)            q <= '0;
        else if (all_valid) q <= d;
        else if (all_null)  q <= '0;
      end

      // R8: a partial input state keeps whatever is held
      p_dims_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!all_valid && !all_null && !bad) |=> $stable(q));
      // R7: nothing leaves NULL before both operands are valid
      p_dims_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (!all_valid && !bad && q == '0) |=> (q == '0));
    end else begin : g_early
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end
  endgenerate

  assign q_valid = q.t | q.f;

  // R2: NULL in gives NULL out in either mode
  p_null_out_r2: assert property (@(posedge clk) disable iff (rst)
    all_null |=> (q == '0));
  // R11: both operands valid at an edge give a valid result after it
  p_resolve_r11: assert property (@(posedge clk) disable iff (rst)
    (all_valid && !bad) |=> q_valid);
endmodule

// File: rtl/eo_gate.sv
module eo_gate #(
  parameter bit            IS_OR = 1'b1,
  parameter bit            INV_A = 1'b0,
  parameter bit            INV_B = 1'b0,
  parameter bit            INV_Y = 1'b0,
  parameter eo_pkg::mode_e MODE  = eo_pkg::EO_EARLY
) (
  input  logic clk,
  input  logic rst,
  input  logic a_t,
  input  logic a_f,
  input  logic b_t,
  input  logic b_f,
  output logic y_t,
  output logic y_f,
  output logic y_valid,
  output logic in_fault
);
  import eo_pkg::*;

  rail_t a_raw, b_raw, a_eff, b_eff, y_pre, y_out, y_q;
  logic  all_valid, all_null, bad;

  assign a_raw = '{t: a_t, f: a_f};
  assign b_raw = '{t: b_t, f: b_f};

  eo_rail_swap #(.SWAP(INV_A)) u_swap_a (.din(a_raw), .dout(a_eff));
  eo_rail_swap #(.SWAP(INV_B)) u_swap_b (.din(b_raw), .dout(b_eff));

  eo_resolve #(.IS_OR(IS_OR)) u_resolve (
    .a(a_eff), .b(b_eff), .y(y_pre),
    .all_valid(all_valid), .all_null(all_null), .bad(bad)
  );

  eo_rail_swap #(.SWAP(INV_Y)) u_swap_y (.din(y_pre), .dout(y_out));

  eo_hold #(.MODE(MODE)) u_hold (
    .clk(clk), .rst(rst), .d(y_out),
    .all_valid(all_valid), .all_null(all_null), .bad(bad),
    .q(y_q), .q_valid(y_valid), .fault(in_fault)
  );

  assign y_t = y_q.t;
  assign y_f = y_q.f;

  // checker view at the pins: controlling value seen on raw rails
  localparam bit CTRL_V = IS_OR;
  localparam bit A_RAW  = CTRL_V ^ INV_A;
  localparam bit B_RAW  = CTRL_V ^ INV_B;
  localparam bit Y_RAW  = CTRL_V ^ INV_Y;

  logic pin_bad, a_ctrl, b_ctrl, y_hit;
  assign pin_bad = (a_t & a_f) | (b_t & b_f);
  assign a_ctrl  = A_RAW ? (a_t & ~a_f) : (a_f & ~a_t);
  assign b_ctrl  = B_RAW ? (b_t & ~b_f) : (b_f & ~b_t);
  assign y_hit   = Y_RAW ? y_t : y_f;

  // R3/R5: one controlling operand settles the result in early mode
  p_early_r3: assert property (@(posedge clk) disable iff (rst)
    ((MODE == EO_EARLY) && !pin_bad && (a_ctrl || b_ctrl)) |=> y_hit);
  // R2: legal operands never produce both result rails
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    (!pin_bad && !$past(pin_bad)) |=> $onehot0({y_t, y_f}));
endmodule

// File: tb/tb_eo_gate.sv
`timescale 1ns/100ps
module tb_eo_gate;
  localparam int NI = 5;
  localparam int NUL = 0, ZRO = 1, ONE = 2, ILL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_t = 1'b0, a_f = 1'b0, b_t = 1'b0, b_f = 1'b0;
  logic yt [NI];
  logic yf [NI];
  logic yv [NI];
  logic fl [NI];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [1:0] mdl [NI];

  always #2.5 clk = ~clk;

  eo_gate #(.IS_OR(1'b1)) dut (.clk(clk), .rst(rst), .a_t(a_t), .a_f(a_f),
    .b_t(b_t), .b_f(b_f), .y_t(yt[0]), .y_f(yf[0]), .y_valid(yv[0]), .in_fault(fl[0]));
  eo_gate #(.IS_OR(1'b0)) dut_and (.clk(clk), .rst(rst), .a_t(a_t), .a_f(a_f),
    .b_t(b_t), .b_f(b_f), .y_t(yt[1]), .y_f(yf[1]), .y_valid(yv[1]), .in_fault(fl[1]));
  eo_gate #(.IS_OR(1'b1), .INV_A(1'b1), .INV_Y(1'b1)) dut_inv (.clk(clk), .rst(rst),
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .y_t(yt[2]), .y_f(yf[2]),
    .y_valid(yv[2]), .in_fault(fl[2]));
  eo_gate #(.IS_OR(1'b1), .MODE(eo_pkg::EO_DIMS)) dut_dor (.clk(clk), .rst(rst),
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .y_t(yt[3]), .y_f(yf[3]),
    .y_valid(yv[3]), .in_fault(fl[3]));
  eo_gate #(.IS_OR(1'b0), .INV_B(1'b1), .MODE(eo_pkg::EO_DIMS)) dut_dand (.clk(clk),
    .rst(rst), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .y_t(yt[4]), .y_f(yf[4]),
    .y_valid(yv[4]), .in_fault(fl[4]));

  function automatic bit c_or(int k);  return (k == 0 || k == 2 || k == 3); endfunction
  function automatic bit c_ia(int k);  return (k == 2); endfunction
  function automatic bit c_ib(int k);  return (k == 4); endfunction
  function automatic bit c_iy(int k);  return (k == 2); endfunction
  function automatic bit c_dm(int k);  return (k >= 3); endfunction
  function automatic string req_of(int k);
    case (k)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  // value code: 0 NULL, 1 logic 0, 2 logic 1
  function automatic int inv_code(int c, bit inv);
    if (!inv || c == NUL) return c;
    return (c == ZRO) ? ONE : ZRO;
  endfunction

  function automatic logic [1:0] rails(int c);
    return (c == ONE) ? 2'b10 : (c == ZRO) ? 2'b01 : 2'b00;
  endfunction

  function automatic int early_val(int k, int a, int b);
    int ea, eb, r;
    ea = inv_code(a, c_ia(k));
    eb = inv_code(b, c_ib(k));
    if (c_or(k)) begin
      if (ea == ONE || eb == ONE)      r = ONE;
      else if (ea == ZRO && eb == ZRO) r = ZRO;
      else                             r = NUL;
    end else begin
      if (ea == ZRO || eb == ZRO)      r = ZRO;
      else if (ea == ONE && eb == ONE) r = ONE;
      else                             r = NUL;
    end
    return inv_code(r, c_iy(k));
  endfunction

  task automatic check(string req, string what, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(int a, int b);
    a_t = (a == ONE || a == ILL);
    a_f = (a == ZRO || a == ILL);
    b_t = (b == ONE || b == ILL);
    b_f = (b == ZRO || b == ILL);
  endtask

  // drive on a falling edge, result checked one falling edge later
  task automatic apply(int a, int b, string tag);
    drive(a, b);
    @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      logic [1:0] e;
      string r;
      e = rails(early_val(k, a, b));
      if (!c_dm(k))                    mdl[k] = e;
      else if (a != NUL && b != NUL)   mdl[k] = e;
      else if (a == NUL && b == NUL)   mdl[k] = 2'b00;
      r = (tag == "") ? req_of(k) : tag;
      check(r, $sformatf("cfg%0d a=%0d b=%0d", k, a, b), {yt[k], yf[k]}, mdl[k]);
      check("R9", $sformatf("cfg%0d valid", k), {1'b0, yv[k]}, {1'b0, |mdl[k]});
      check("R10", $sformatf("cfg%0d fault low", k), {1'b0, fl[k]}, 2'b00);
    end
  endtask

  task automatic t_reset_r1;
    rst = 1'b1;
    drive(ONE, ONE);
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      check("R1", $sformatf("cfg%0d reset rails", k), {yt[k], yf[k]}, 2'b00);
      check("R1", $sformatf("cfg%0d reset flags", k), {yv[k], fl[k]}, 2'b00);
      mdl[k] = 2'b00;
    end
    drive(NUL, NUL);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_sweep;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++) begin
        apply(NUL, NUL, "R2");
        apply(a, b, "");
      end
    apply(NUL, NUL, "R2");
  endtask

  task automatic t_early_r3_r4;
    apply(ONE, NUL, "R3");
    check("R3", "OR early one", {yt[0], yf[0]}, 2'b10);
    apply(NUL, NUL, "R2");
    apply(NUL, ZRO, "R4");
    check("R4", "OR single zero stays NULL", {yt[0], yf[0]}, 2'b00);
    check("R5", "AND early zero", {yt[1], yf[1]}, 2'b01);
    apply(NUL, NUL, "R2");
  endtask

  task automatic t_dims_hold_r7_r8;
    apply(ONE, NUL, "R7");
    check("R7", "DIMS OR waits", {yt[3], yf[3]}, 2'b00);
    apply(ONE, ZRO, "R7");
    check("R7", "DIMS OR resolves", {yt[3], yf[3]}, 2'b10);
    apply(NUL, ZRO, "R8");
    check("R8", "DIMS OR holds", {yt[3], yf[3]}, 2'b10);
    check("R8", "DIMS AND holds", {yt[4], yf[4]}, 2'b10);
    apply(NUL, NUL, "R8");
    check("R8", "DIMS OR released", {yt[3], yf[3]}, 2'b00);
  endtask

  task automatic t_latency_r11;
    drive(ONE, ONE);
    #1;
    check("R11", "no change before edge", {yt[0], yf[0]}, 2'b00);
    apply(ONE, ONE, "R11");
    check("R11", "result after edge", {yt[0], yf[0]}, 2'b10);
    apply(NUL, NUL, "R2");
  endtask

  task automatic t_fault_r10;
    drive(ILL, NUL);
    @(negedge clk);
    check("R10", "fault raised", {1'b0, fl[0]}, 2'b01);
    check("R10", "fault raised dims", {1'b0, fl[3]}, 2'b01);
    apply(NUL, NUL, "R10");
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int k = 0; k < NI; k++) mdl[k] = 2'b00;
    t_reset_r1();
    t_sweep();
    t_early_r3_r4();
    t_dims_hold_r7_r8();
    t_latency_r11();
    t_fault_r10();
    t_sweep();
    finish_up();
  end

  initial begin
    #20000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule